// File: doc/BRIEF.md
# Dual-Rail Word Completion Detector

This block watches a data word carried on pairs of wires, one pair per bit, and reports when the whole word has arrived and when the whole word has been cleared again. A pair with both wires low is the spacer, meaning no data. A pair with one wire high carries a bit value. The block ORs the two wires of each pair to get a per-bit presence signal. It then merges all the presence signals in a state-holding element that behaves like a multi-input Muller C-element, clocked by the system clock.

The completion flag goes high once every bit is present. It goes low once every bit has returned to the spacer. For any mix of present and empty bits it keeps its last value, so a return-to-zero handshake sees one clean edge per phase. The block also provides the single-rail value of the word, taken from the true wires and forced to zero while the flag is low. A combinational flag marks any pair that has both wires high.

Top module: `dr_completion_detect`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising clock edge, `done` is 0 after that edge.
- R2: If every bit pair shows a code at a rising edge (true or false wire high, i.e. OR of the pair is 1 for all bits), `done` is 1 after that edge.
- R3: When `done` is 1 and the word holds a mix of present and spacer (both wires 0) pairs, `done` stays 1.
- R4: If every bit pair is spacer (`rail_t` and `rail_f` all zero) at a rising edge, `done` is 0 after that edge.
- R5: When `done` is 0 and the word holds a mix of present and spacer pairs, `done` stays 0.
- R6: While `done` is 1, `data_out` equals `rail_t` bit for bit (true wire high encodes logic 1, false wire high encodes logic 0).
- R7: While `done` is 0, `data_out` is all zeros.
- R8: `illegal` is 1 in the same cycle that any bit has both `rail_t` and `rail_f` high, and 0 otherwise; such a pair still counts as present for the merge.
- R9: Reset takes priority over a fully present word: `done` is 0 after an edge with `rst` high even when all pairs show a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the merge state |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | WIDTH | True wire of each bit pair |
| rail_f | input | WIDTH | False wire of each bit pair |
| done | output | 1 | Completion flag with hysteresis |
| data_out | output | WIDTH | Single-rail word, zero while `done` is low |
| illegal | output | 1 | Some bit pair has both wires high |

## Verification
The assertions assume the rail inputs are stable across each rising edge and take a defined value after reset, since the merge samples them only at the clock. They do not assume legal codes: the both-high pattern is treated as present, and the bench applies it on purpose to check that the merge still behaves. The stimulus changes the rails only on the falling edge and walks the word through spacer, partial, full and back-to-spacer phases, including full-to-full transitions with no spacer between them.

// File: rtl/dr_completion_detect.sv
module dr_completion_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             done,
  output logic [WIDTH-1:0] data_out,
  output logic             illegal
);

  logic [WIDTH-1:0] present;
  logic             all_set;
  logic             all_clear;
  logic             merge_q;

  assign present   = rail_t | rail_f;
  assign all_set   = &present;
  assign all_clear = ~|present;

  always_ff @(posedge clk) begin
    if (rst)            merge_q <= 1'b0;
    else if (all_set)   merge_q <= 1'b1;
    else if (all_clear) merge_q <= 1'b0;
  end

  assign done     = merge_q;
  assign data_out = merge_q ? rail_t : '0;
  assign illegal  = |(rail_t & rail_f);

  // R2
  rise_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    (&(rail_t | rail_f)) |=> done);

  // R4
  fall_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (~|(rail_t | rail_f)) |=> !done);

  // R3 R5
  hold_on_mixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&(rail_t | rail_f)) && (|(rail_t | rail_f))) |=> $stable(done));

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(&(rail_t | rail_f)));

  // R6 R7
  data_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (|data_out) |-> done);

endmodule

// File: tb/dr_completion_detect_bench.sv
module dr_completion_detect_bench;
  localparam int W = 8;
  localparam int NV = 19;
  // fields: rst, rail_t, rail_f, exp_done, exp_data, exp_illegal
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b0}, // R1 R9
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 R7
    {1'b0, 8'h0F, 8'h00, 1'b0, 8'h00, 1'b0}, // R5 R7
    {1'b0, 8'hA5, 8'h5A, 1'b1, 8'hA5, 1'b0}, // R2 R6
    {1'b0, 8'hA0, 8'h50, 1'b1, 8'hA0, 1'b0}, // R3 R6
    {1'b0, 8'h00, 8'h01, 1'b1, 8'h00, 1'b0}, // R3
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R4
    {1'b0, 8'h3C, 8'hC3, 1'b1, 8'h3C, 1'b0}, // R2
    {1'b0, 8'h3C, 8'hC3, 1'b1, 8'h3C, 1'b0}, // R2
    {1'b0, 8'hFF, 8'h00, 1'b1, 8'hFF, 1'b0}, // R2 full to full
    {1'b0, 8'h01, 8'h01, 1'b1, 8'h01, 1'b1}, // R3 R8
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 R8
    {1'b0, 8'h70, 8'h00, 1'b0, 8'h00, 1'b0}, // R5
    {1'b0, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1}, // R8 R2
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // R4
    {1'b0, 8'h00, 8'hFF, 1'b1, 8'h00, 1'b0}, // R2 R6
    {1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b0}, // R9
    {1'b0, 8'h00, 8'hFF, 1'b1, 8'h00, 1'b0}, // R2
    {1'b0, 8'h80, 8'h00, 1'b1, 8'h80, 1'b0}  // R3 R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] rail_t = '0;
  logic [W-1:0] rail_f = '0;
  logic done;
  logic [W-1:0] data_out;
  logic illegal;
  int runs = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  dr_completion_detect #(.WIDTH(W)) u_dr_completion_detect (
    .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
    .done(done), .data_out(data_out), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [W-1:0] t, input logic [W-1:0] f);
    @(negedge clk);
    rst = r; rail_t = t; rail_f = f;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 100000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    step(1'b1, '0, '0);
    chk("R1 done after reset", {7'b0, done}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
      chk($sformatf("R2/R3/R4/R5/R9 done row %0d", i), {7'b0, done}, {7'b0, VEC[i][9]});
      chk($sformatf("R6/R7 data_out row %0d", i), data_out, VEC[i][8:1]);
      chk($sformatf("R8 illegal row %0d", i), {7'b0, illegal}, {7'b0, VEC[i][0]});
    end
    // R3: long partial hold with bits dropping one at a time
    step(1'b0, 8'hFF, 8'h00);
    for (int k = 0; k < W - 1; k++) begin
      step(1'b0, 8'hFF >> (k + 1), 8'h00);
      chk("R3 hold while draining", {7'b0, done}, 8'h01);
    end
    step(1'b0, 8'h00, 8'h00);
    chk("R4 drained", {7'b0, done}, 8'h00);
    chk("R7 data zero when idle", data_out, 8'h00);
    // R5: fill one bit at a time
    for (int k = 0; k < W - 1; k++) begin
      step(1'b0, 8'h00, ~(8'hFF << (k + 1)));
      chk("R5 hold while filling", {7'b0, done}, 8'h00);
    end
    step(1'b0, 8'h00, 8'hFF);
    chk("R2 filled", {7'b0, done}, 8'h01);
    // R8: illegal is combinational, seen before the edge
    @(negedge clk);
    rail_t = 8'h10; rail_f = 8'hFF;
    #2;
    chk("R8 illegal same cycle", {7'b0, illegal}, 8'h01);
    // R1: reset from a held-high state with a partial word
    step(1'b1, 8'h01, 8'h00);
    chk("R1 reset clears done", {7'b0, done}, 8'h00);
    step(1'b0, 8'h01, 8'h00);
    chk("R5 partial after reset", {7'b0, done}, 8'h00);
    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule